// File: doc/BRIEF.md
# Offset-Corrected Temperature Limit Comparator with Alert

This block sits behind a temperature measurement front end. Each time a conversion completes, it captures a local 8-bit reading and a remote 8-bit reading. It adds a signed trim to the remote reading, clamping the sum to the signed 8-bit range. It then holds both corrected values for readback.

The block checks each channel against its own high and low window limits. High limits use strictly-greater tests and low limits use strictly-less tests, with all operands signed. Every violation sets a sticky status flag, and a remote open-circuit indication sets a flag of its own. An active-low alert output pulls low while any flag is set, unless the configuration mask bit is set. A status-clear strobe empties the flags.

Software reaches the registers through a one-cycle parallel write port and a combinational read port. The address codes are listed in R2.

Top module: `temp_limit_alert`

## Requirements
- R1: After reset the registers hold the following values: mask 0, trim 0, both high limits 0x7F, both low limits 0x80, both stored temperatures 0 and status 0. The alert output is high.
- R2: The register codes are as follows:
  - 0 is config, with the mask in bit 7; the other bits read 0.
  - 1 is the remote trim.
  - 2 is the local high limit and 3 is the local low limit.
  - 4 is the remote high limit and 5 is the remote low limit.
  - 6 is the local temperature and 7 is the remote temperature.
  - 8 is status.

  Codes 0 to 5 are writable. Writes to codes 6 to 15 change nothing. Reads of codes 9 to 15 return 0.
- R3: On a conversion, the stored remote temperature is the signed raw remote reading plus the signed trim, saturated to the range -128 to +127. For example, trim 0xFC with 18 gives 14, and trim 0x04 with 18 gives 22. The local temperature is stored unchanged.
- R4: A high flag is set only when the reading is strictly greater than the high limit. Status bit 0 is the local high flag and bit 2 is the remote high flag.
- R5: A low flag is set only when the reading is strictly less than the low limit. Status bit 1 is the local low flag and bit 3 is the remote low flag.
- R6: All comparisons are signed, so negative limits behave as two's-complement values.
- R7: Status flags are sticky. The clear strobe zeroes them. A flag raised by a conversion in the same cycle as a clear survives the clear.
- R8: A conversion that arrives with the open-circuit input high sets status bit 4. That conversion neither updates the remote temperature nor evaluates the remote limits.
- R9: The alert output is low exactly when some status flag is set and the mask bit is 0. Setting the mask raises the alert output and leaves the flags intact.
- R10: A conversion compares against the limit values held before any write in the same cycle.
- R11: Without a conversion strobe, the stored temperatures do not change and no status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write register code |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read register code |
| rd_data_o | output | 8 | Read data (combinational) |
| conv_done_i | input | 1 | Conversion complete strobe |
| local_raw_i | input | 8 | Local reading |
| remote_raw_i | input | 8 | Remote reading, before trim |
| open_i | input | 1 | Remote sensor open-circuit indication |
| stat_clr_i | input | 1 | Status clear strobe |
| status_o | output | 5 | Sticky status flags |
| alert_no | output | 1 | Alert, active low |

## Verification
The assertions assume the following about the inputs:
- The conversion and clear strobes last one cycle per event.
- The raw readings and the open-circuit input are valid whenever the conversion strobe is high.

The stimulus drives every input at the falling edge and holds each strobe for exactly one cycle. A behavioural model in the bench mirrors the register state. The model applies conversions before writes within a cycle, so same-cycle limit updates and clear/set races are predicted independently of the RTL.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;
  localparam int unsigned NCH = 2;            // 0 local, 1 remote
  localparam int unsigned SW = 2 * NCH + 1;   // hi/lo per channel + open

  typedef enum logic [AW-1:0] {
    REG_CFG    = 4'd0,
    REG_TRIM   = 4'd1,
    REG_LHI    = 4'd2,
    REG_LLO    = 4'd3,
    REG_RHI    = 4'd4,
    REG_RLO    = 4'd5,
    REG_LTEMP  = 4'd6,
    REG_RTEMP  = 4'd7,
    REG_STATUS = 4'd8
  } reg_code_e;

  localparam int unsigned ST_OPEN = 2 * NCH;
  localparam int unsigned CFG_MASK_BIT = DW - 1;
endpackage

// File: rtl/tla_regs.sv
module tla_regs
  import temp_alert_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [W-1:0]        wr_data_i,
  output logic                mask_o,
  output logic [W-1:0]        trim_o,
  output logic [NCH-1:0][W-1:0] lim_hi_o,
  output logic [NCH-1:0][W-1:0] lim_lo_o
);
  localparam logic [W-1:0] HI_RST = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] LO_RST = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= 1'b0;
      trim_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_CFG)  mask_o <= wr_data_i[CFG_MASK_BIT];
      if (wr_addr_i == REG_TRIM) trim_o <= wr_data_i;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lim
    localparam logic [AW-1:0] HI_CODE = AW'(REG_LHI) + AW'(2 * c);
    localparam logic [AW-1:0] LO_CODE = AW'(REG_LLO) + AW'(2 * c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lim_hi_o[c] <= HI_RST;
        lim_lo_o[c] <= LO_RST;
      end else if (wr_en_i) begin
        if (wr_addr_i == HI_CODE) lim_hi_o[c] <= wr_data_i;
        if (wr_addr_i == LO_CODE) lim_lo_o[c] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/tla_trim_sat.sv
module tla_trim_sat #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] trim_i,
  output logic [W-1:0] adj_o
);
  logic [W:0] sum;
  always_comb begin
    sum = {raw_i[W-1], raw_i} + {trim_i[W-1], trim_i};
    if (sum[W] != sum[W-1])
      adj_o = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      adj_o = sum[W-1:0];
  end
endmodule

// File: rtl/tla_window_cmp.sv
module tla_window_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic         above_o,
  output logic         below_o
);
  assign above_o = $signed(val_i) > $signed(hi_i);
  assign below_o = $signed(val_i) < $signed(lo_i);
endmodule

// File: rtl/tla_status.sv
module tla_status #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  // new events outrank a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (clr_i ? '0 : flags_o) | set_i;
  end
endmodule

// File: rtl/temp_limit_alert.sv
module temp_limit_alert
  import temp_alert_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          conv_done_i,
  input  logic [DW-1:0] local_raw_i,
  input  logic [DW-1:0] remote_raw_i,
  input  logic          open_i,
  input  logic          stat_clr_i,
  output logic [SW-1:0] status_o,
  output logic          alert_no
);
  logic                    cfg_mask;
  logic [DW-1:0]           trim_q;
  logic [NCH-1:0][DW-1:0]  lim_hi, lim_lo;
  logic [NCH-1:0][DW-1:0]  reading;
  logic [NCH-1:0][DW-1:0]  temp_q;
  logic [NCH-1:0]          above, below, ch_valid;
  logic [SW-1:0]           set_vec;

  tla_regs #(.W(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mask_o(cfg_mask), .trim_o(trim_q), .lim_hi_o(lim_hi), .lim_lo_o(lim_lo)
  );

  assign reading[0] = local_raw_i;
  tla_trim_sat #(.W(DW)) u_trim (
    .raw_i(remote_raw_i), .trim_i(trim_q), .adj_o(reading[1])
  );

  assign ch_valid[0] = conv_done_i;
  assign ch_valid[1] = conv_done_i && !open_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tla_window_cmp #(.W(DW)) u_cmp (
      .val_i(reading[c]), .hi_i(lim_hi[c]), .lo_i(lim_lo[c]),
      .above_o(above[c]), .below_o(below[c])
    );
    assign set_vec[2*c]   = ch_valid[c] && above[c];
    assign set_vec[2*c+1] = ch_valid[c] && below[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          temp_q[c] <= '0;
      else if (ch_valid[c]) temp_q[c] <= reading[c];
    end
  end
  assign set_vec[ST_OPEN] = conv_done_i && open_i;

  tla_status #(.N(SW)) u_stat (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(stat_clr_i), .flags_o(status_o)
  );

  assign alert_no = !((|status_o) && !cfg_mask);

  always_comb begin
    unique case (rd_addr_i)
      REG_CFG:    rd_data_o = DW'(cfg_mask) << CFG_MASK_BIT;
      REG_TRIM:   rd_data_o = trim_q;
      REG_LHI:    rd_data_o = lim_hi[0];
      REG_LLO:    rd_data_o = lim_lo[0];
      REG_RHI:    rd_data_o = lim_hi[1];
      REG_RLO:    rd_data_o = lim_lo[1];
      REG_LTEMP:  rd_data_o = temp_q[0];
      REG_RTEMP:  rd_data_o = temp_q[1];
      REG_STATUS: rd_data_o = DW'(status_o);
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/tla_checker.sv
module tla_checker
  import temp_alert_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          conv_done_i,
  input logic          stat_clr_i,
  input logic          open_i,
  input logic [DW-1:0] remote_raw_i,
  input logic [SW-1:0] status_o,
  input logic          alert_no,
  input logic          cfg_mask,
  input logic [DW-1:0] trim_q,
  input logic [DW-1:0] remote_temp
);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !conv_done_i) |=> (status_o == '0));

  assert_no_new_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> ((status_o | $past(status_o)) == $past(status_o)));

  assert_alert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o == '0) || cfg_mask) |-> alert_no);

  assert_alert_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o != '0) && !cfg_mask) |-> !alert_no);

  assert_open_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && open_i) |=> status_o[ST_OPEN]);

  assert_open_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && open_i) |=> $stable(remote_temp));

  assert_zero_trim_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !open_i && trim_q == '0) |=> (remote_temp == $past(remote_raw_i)));
endmodule

bind temp_limit_alert tla_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .conv_done_i(conv_done_i),
  .stat_clr_i(stat_clr_i), .open_i(open_i), .remote_raw_i(remote_raw_i),
  .status_o(status_o), .alert_no(alert_no), .cfg_mask(cfg_mask),
  .trim_q(trim_q), .remote_temp(temp_q[1])
);

// File: tb/sim_temp_limit_alert.sv
`timescale 1ns/1ps
module sim_temp_limit_alert;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, conv = 1'b0, open_c = 1'b0, clr = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, lraw = '0, rraw = '0;
  logic [7:0] rd_data;
  logic [4:0] status;
  logic alert_n;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  temp_limit_alert u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .conv_done_i(conv), .local_raw_i(lraw), .remote_raw_i(rraw),
    .open_i(open_c), .stat_clr_i(clr), .status_o(status), .alert_no(alert_n)
  );

  // behavioural model
  bit m_mask;
  logic [7:0] m_trim, m_lhi, m_llo, m_rhi, m_rlo, m_lt, m_rt;
  logic [4:0] m_st;

  function automatic int s8(logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic logic [7:0] model_rd(logic [3:0] a);
    case (a)
      0: return {m_mask, 7'b0};
      1: return m_trim;
      2: return m_lhi;
      3: return m_llo;
      4: return m_rhi;
      5: return m_rlo;
      6: return m_lt;
      7: return m_rt;
      8: return {3'b0, m_st};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_mask = 0; m_trim = 0; m_lhi = 8'h7F; m_llo = 8'h80;
      m_rhi = 8'h7F; m_rlo = 8'h80; m_lt = 0; m_rt = 0; m_st = 0;
    end else begin
      logic [4:0] nset;
      nset = 0;
      if (conv) begin
        int r;
        r = s8(rraw) + s8(m_trim);
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        if (s8(lraw) > s8(m_lhi)) nset[0] = 1;
        if (s8(lraw) < s8(m_llo)) nset[1] = 1;
        m_lt = lraw;
        if (open_c) nset[4] = 1;
        else begin
          if (r > s8(m_rhi)) nset[2] = 1;
          if (r < s8(m_rlo)) nset[3] = 1;
          m_rt = 8'(r);
        end
      end
      m_st = (clr ? 5'b0 : m_st) | nset;
      if (wr_en) case (wr_addr)
        0: m_mask = wr_data[7];
        1: m_trim = wr_data;
        2: m_lhi = wr_data;
        3: m_llo = wr_data;
        4: m_rhi = wr_data;
        5: m_rlo = wr_data;
        default: ;
      endcase
    end
    #1;
    if (!done) begin
      chk("rd_data", rd_data, model_rd(rd_addr));
      chk("status", status, m_st);
      chk("alert_n", alert_n, !((m_st != 0) && !m_mask));
    end
  end

  task automatic step(bit we, logic [3:0] wa, logic [7:0] wd,
                      bit cv, logic [7:0] l, logic [7:0] r, bit op, bit cl);
    wr_en = we; wr_addr = wa; wr_data = wd;
    conv = cv; lraw = l; rraw = r; open_c = op; clr = cl;
    @(negedge clk);
    wr_en = 0; conv = 0; clr = 0; open_c = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic cv(logic [7:0] l, logic [7:0] r, bit op);
    step(0, 0, 0, 1, l, r, op, 0);
  endtask

  task automatic clear();
    step(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1"; sweep();
    rst_ni = 1'b1;
    sweep();

    cur_req = "R2";
    wr(0, 8'hFF); wr(1, 8'h05); wr(2, 8'h50); wr(3, 8'h0A); wr(4, 8'h60); wr(5, 8'h05);
    for (int a = 6; a < 16; a++) wr(4'(a), 8'hA5);
    sweep();
    wr(0, 8'h00); wr(1, 8'h00);

    cur_req = "R4"; rd_addr = 8;
    cv(8'd80, 8'd20, 0); cv(8'd81, 8'd20, 0); clear();
    wr(4, 8'd50); cv(8'd20, 8'd50, 0); cv(8'd20, 8'd51, 0); clear();

    cur_req = "R5";
    cv(8'd10, 8'd20, 0); cv(8'd9, 8'd20, 0); clear();
    cv(8'd20, 8'd5, 0); cv(8'd20, 8'd4, 0); clear();

    cur_req = "R6";
    wr(2, 8'hF6); wr(3, 8'hF0);
    cv(8'hF6, 8'd20, 0); cv(8'd0, 8'd20, 0); clear();
    cv(8'hF0, 8'd20, 0); cv(8'hEF, 8'd20, 0); clear();
    wr(2, 8'h7F); wr(3, 8'h80);

    cur_req = "R3"; wr(4, 8'h7F); wr(5, 8'h80); rd_addr = 7;
    wr(1, 8'hFC); cv(8'd18, 8'd18, 0);
    wr(1, 8'h04); cv(8'd18, 8'd18, 0);
    wr(1, 8'hFF); cv(8'd18, 8'd18, 0);
    wr(1, 8'h7F); cv(8'd0, 8'd100, 0);
    wr(1, 8'h80); cv(8'd0, 8'hF0, 0);
    wr(1, 8'h80); cv(8'd0, 8'h7F, 0);
    rd_addr = 6; cv(8'd33, 8'd1, 0);
    wr(1, 8'h00);

    cur_req = "R8"; rd_addr = 7;
    cv(8'd40, 8'd44, 0);
    wr(4, 8'd10); cv(8'd40, 8'd90, 1); rd_addr = 8; @(negedge clk); clear();
    wr(4, 8'h7F);

    cur_req = "R9";
    cv(8'd127, 8'd0, 1); wr(0, 8'h80); @(negedge clk);
    wr(0, 8'h7F); @(negedge clk); clear(); @(negedge clk);

    cur_req = "R7";
    wr(2, 8'd30);
    cv(8'd31, 8'd0, 0); repeat (3) @(negedge clk);
    step(0, 0, 0, 1, 8'd31, 8'd0, 0, 1); @(negedge clk);
    step(0, 0, 0, 1, 8'd20, 8'd0, 1, 1); @(negedge clk); clear();

    cur_req = "R10";
    step(1, 2, 8'd100, 1, 8'd50, 8'd0, 0, 0); @(negedge clk); clear();
    step(1, 3, 8'd60, 1, 8'd50, 8'd0, 0, 0); @(negedge clk); clear();
    wr(2, 8'h7F); wr(3, 8'h80);

    cur_req = "R11";
    lraw = 8'd99; rraw = 8'd99; rd_addr = 6; repeat (3) @(negedge clk);
    rd_addr = 7; repeat (3) @(negedge clk);
    rd_addr = 8; open_c = 0; repeat (3) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule